// File: doc/BRIEF.md
# Angle PWM Frame Encoder

This block turns a 12-bit angle word and a fault flag into a repeating pulse-width frame on one output. Each frame is built from four sections of fixed length. A leading high run comes first. A short status run follows, carrying the inverted fault flag. Next is a long data run, whose number of high ticks equals the angle. A trailing low run closes the frame. The receiver measures the whole frame, so it can recover the angle without knowing the exact tick rate.

Time advances only on cycles where the tick enable is high. The block takes the angle and the fault flag on the first tick of every frame and keeps them until the frame ends, so a change in the inputs during a frame can never split one frame between two values. A one-cycle frame-start pulse marks the edge on which the first tick of each frame is shown on the output.

Top module: `angle_pwm_encoder`

## Requirements
- R1: While reset is held, `pwm_o` and `frame_start_o` are 0. After reset is released, the first tick begins a new frame.
- R2: A frame is exactly 4119 ticks long and frames follow each other with no gap. `frame_start_o` is high for one clock, in the clock after the tick that emits the first position of a frame.
- R3: Ticks 0 to 11 of a frame drive `pwm_o` high.
- R4: Ticks 12 to 15 drive `pwm_o` to the inverse of the captured fault flag.
- R5: Ticks 16 to 4110 form the data section. When there is no fault, the first A of these ticks are high and the rest are low, where A is the captured angle (0 to 4095). A = 0 gives no high tick and A = 4095 makes the whole section high.
- R6: When the captured fault flag is 1, every tick of the data section is low, whatever the angle.
- R7: Ticks 4111 to 4118 drive `pwm_o` low.
- R8: `angle_i` and `err_i` are sampled only on the first tick of a frame. Changes at any other time do not affect the frame in progress.
- R9: On a cycle without a tick, `pwm_o` keeps its value and `frame_start_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Advances the frame by one position |
| angle_i | input | 12 | Angle to encode |
| err_i | input | 1 | Fault flag; 1 blanks the data section |
| pwm_o | output | 1 | Frame output, registered |
| frame_start_o | output | 1 | One-clock mark for the first tick of a frame |

## Verification
The angle is tried at both ends of its range (0 and 4095), one step in from each end (1 and 4094), and at several values in between, with the fault flag clear. This separates an off-by-one in the data length from an off-by-one in the comparison. The fault flag is then raised with a zero angle, a mid angle and a full-scale angle; only a blanked data section passes all three. In every frame the inputs are swapped for their bitwise complement partway through the data run, and are set to the next value only later. This shows whether capture happens on anything other than the first tick. Two frames run with the tick on every other clock, which checks that lengths are counted in ticks and that the output holds between ticks.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

  typedef enum logic [1:0] {
    SEC_INIT = 2'd0,
    SEC_STAT = 2'd1,
    SEC_DATA = 2'd2,
    SEC_EXIT = 2'd3
  } sec_e;

  // Total ticks in one frame from its four section lengths.
  function automatic int unsigned frame_ticks(int unsigned init_len, int unsigned stat_len,
                                              int unsigned data_len, int unsigned exit_len);
    return init_len + stat_len + data_len + exit_len;
  endfunction

  // Level driven for one tick, given the section and the captured inputs.
  function automatic logic sec_level(sec_e sec, logic fault, logic [31:0] data_idx,
                                     logic [31:0] angle);
    case (sec)
      SEC_INIT: return 1'b1;
      SEC_STAT: return !fault;
      SEC_DATA: return !fault && (data_idx < angle);
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/apwm_frame_counter.sv
module apwm_frame_counter #(
  parameter int unsigned FRAME_LEN = 4119,
  parameter int unsigned POS_W     = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [POS_W-1:0] pos_o,
  output logic             first_o,
  output logic             last_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pos_q <= '0;
    else if (tick_i) pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
  end

  assign pos_o   = pos_q;
  assign first_o = (pos_q == '0);
  assign last_o  = (pos_q == LAST_POS);

  // R2: the last position is followed by the first one
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && last_o |=> first_o);
  // R2: the position never leaves the frame
  p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_o <= LAST_POS);
endmodule

// File: rtl/apwm_section_decode.sv
module apwm_section_decode
  import apwm_pkg::*;
#(
  parameter int unsigned INIT_LEN = 12,
  parameter int unsigned STAT_LEN = 4,
  parameter int unsigned DATA_LEN = 4095,
  parameter int unsigned POS_W    = 13
) (
  input  logic [POS_W-1:0] pos_i,
  output sec_e             sec_o,
  output logic [POS_W-1:0] data_idx_o
);
  localparam logic [POS_W-1:0] END_INIT = POS_W'(INIT_LEN);
  localparam logic [POS_W-1:0] END_STAT = POS_W'(INIT_LEN + STAT_LEN);
  localparam logic [POS_W-1:0] END_DATA = POS_W'(INIT_LEN + STAT_LEN + DATA_LEN);

  always_comb begin
    if (pos_i < END_INIT)      sec_o = SEC_INIT;
    else if (pos_i < END_STAT) sec_o = SEC_STAT;
    else if (pos_i < END_DATA) sec_o = SEC_DATA;
    else                       sec_o = SEC_EXIT;
    data_idx_o = pos_i - END_STAT;
  end
endmodule

// File: rtl/apwm_sample_hold.sv
module apwm_sample_hold #(
  parameter int unsigned ANG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ANG_W-1:0] angle_i,
  input  logic             err_i,
  output logic [ANG_W-1:0] angle_o,
  output logic             err_o
);
  logic [ANG_W-1:0] angle_q;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      angle_q <= '0;
      err_q   <= 1'b0;
    end else if (load_i) begin
      angle_q <= angle_i;
      err_q   <= err_i;
    end
  end

  // On the first tick the live inputs are used; the held copy covers the rest.
  assign angle_o = load_i ? angle_i : angle_q;
  assign err_o   = load_i ? err_i   : err_q;

  // R8: without a load the captured values do not move
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(angle_q) && $stable(err_q));
endmodule

// File: rtl/angle_pwm_encoder.sv
module angle_pwm_encoder
  import apwm_pkg::*;
#(
  parameter int unsigned ANG_W    = 12,
  parameter int unsigned INIT_LEN = 12,
  parameter int unsigned STAT_LEN = 4,
  parameter int unsigned EXIT_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [ANG_W-1:0] angle_i,
  input  logic             err_i,
  output logic             pwm_o,
  output logic             frame_start_o
);
  localparam int unsigned DATA_LEN  = (1 << ANG_W) - 1;
  localparam int unsigned FRAME_LEN = frame_ticks(INIT_LEN, STAT_LEN, DATA_LEN, EXIT_LEN);
  localparam int unsigned POS_W     = $clog2(FRAME_LEN + 1);

  logic [POS_W-1:0] pos;
  logic             at_first;
  logic             at_last;
  sec_e             sec;
  logic [POS_W-1:0] data_idx;
  logic [ANG_W-1:0] eff_angle;
  logic             eff_err;
  logic             level_next;
  logic             load_now;
  logic             pwm_q;
  logic             start_q;

  assign load_now = tick_i && at_first;

  apwm_frame_counter #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .pos_o(pos), .first_o(at_first), .last_o(at_last)
  );

  apwm_section_decode #(.INIT_LEN(INIT_LEN), .STAT_LEN(STAT_LEN),
                        .DATA_LEN(DATA_LEN), .POS_W(POS_W)) u_dec (
    .pos_i(pos), .sec_o(sec), .data_idx_o(data_idx)
  );

  apwm_sample_hold #(.ANG_W(ANG_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(load_now),
    .angle_i(angle_i), .err_i(err_i),
    .angle_o(eff_angle), .err_o(eff_err)
  );

  assign level_next = sec_level(sec, eff_err, 32'(data_idx), 32'(eff_angle));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= load_now;
      if (tick_i) pwm_q <= level_next;
    end
  end

  assign pwm_o         = pwm_q;
  assign frame_start_o = start_q;

  // R1: outputs stay quiet while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !pwm_o && !frame_start_o);
  // R9: without a tick the output holds and no frame start is flagged
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pwm_o) && !frame_start_o);
  // R3: the first shown tick of a frame is high
  p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> pwm_o);
  // R4: the status run carries the inverted captured fault
  p_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && sec == SEC_STAT |=> pwm_o == !$past(eff_err));
  // R6: a captured fault blanks the data run
  p_fault_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && sec == SEC_DATA && eff_err |=> !pwm_o);
  // R7: the closing run is low
  p_exit_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && sec == SEC_EXIT |=> !pwm_o);
  // R2: a frame start follows the tick that wraps the frame
  p_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && at_last ##1 tick_i |=> frame_start_o);
endmodule

// File: tb/test_angle_pwm_encoder.sv
module test_angle_pwm_encoder;
  localparam int FRAME  = 4119;
  localparam int NITEMS = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [11:0] angle = '0;
  logic        err = 1'b0;
  logic        pwm;
  logic        fs;
  logic        slow = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  int frames_done = 0;
  bit finished = 0;

  logic [12:0] expq[$];
  logic [12:0] items[NITEMS];
  bit          slow_of[NITEMS];

  always #5 clk = ~clk;

  angle_pwm_encoder i_angle_pwm_encoder (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .angle_i(angle), .err_i(err),
    .pwm_o(pwm), .frame_start_o(fs)
  );

  always @(negedge clk) tick <= !rst_n ? 1'b0 : (slow ? ~tick : 1'b1);

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor state
  bit          in_frame = 0;
  logic [12:0] cur;
  int k, ini_hi, st_hi, dat_hi, ext_hi, idle_bad;
  bit seen_low, torn;
  logic last_pwm;

  task automatic close_frame();
    bit ferr;
    int fang;
    ferr = cur[12];
    fang = int'(cur[11:0]);
    check(k == FRAME, "R2 frame length", k, FRAME);
    check(ini_hi == 12, "R3 leading high ticks", ini_hi, 12);
    check(st_hi == (ferr ? 0 : 4), "R4 status ticks", st_hi, ferr ? 0 : 4);
    if (ferr) check(dat_hi == 0, "R6 R8 blanked data", dat_hi, 0);
    else      check(dat_hi == fang, "R5 R8 data high count", dat_hi, fang);
    check(!torn, "R5 data high run contiguous", int'(torn), 0);
    check(ext_hi == 0, "R7 closing low", ext_hi, 0);
    check(idle_bad == 0, "R9 hold between ticks", idle_bad, 0);
    frames_done++;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      if ($time > 20) begin
        check(pwm == 1'b0, "R1 pwm in reset", int'(pwm), 0);
        check(fs == 1'b0, "R1 frame start in reset", int'(fs), 0);
      end
    end else if (tick) begin
      if (fs) begin
        if (in_frame) close_frame();
        if (expq.size() > 0) begin
          cur = expq.pop_front();
          in_frame = 1;
          k = 0; ini_hi = 0; st_hi = 0; dat_hi = 0; ext_hi = 0; idle_bad = 0;
          seen_low = 0; torn = 0;
        end else in_frame = 0;
      end
      if (in_frame) begin
        if (k < 12) ini_hi += int'(pwm);
        else if (k < 16) st_hi += int'(pwm);
        else if (k < 16 + 4095) begin
          if (pwm) begin
            dat_hi++;
            if (seen_low) torn = 1;
          end else seen_low = 1;
        end else ext_hi += int'(pwm);
        k++;
        last_pwm = pwm;
      end
    end else if (in_frame && (pwm !== last_pwm || fs)) idle_bad++;
  end

  initial begin
    items[0]  = {1'b0, 12'd0};
    items[1]  = {1'b0, 12'd1};
    items[2]  = {1'b0, 12'd2048};
    items[3]  = {1'b0, 12'd4094};
    items[4]  = {1'b0, 12'd4095};
    items[5]  = {1'b1, 12'd1234};
    items[6]  = {1'b1, 12'd0};
    items[7]  = {1'b1, 12'd4095};
    items[8]  = {1'b0, 12'd7};
    items[9]  = {1'b0, 12'd3000};
    items[10] = {1'b0, 12'd100};
    items[11] = {1'b0, 12'd2730};
    for (int i = 0; i < NITEMS; i++) slow_of[i] = (i == 9 || i == 10);

    {err, angle} = items[0];
    expq.push_back(items[0]);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 1; i < NITEMS; i++) begin
      @(posedge fs);
      repeat (50) @(negedge clk);
      {err, angle} = ~items[i];        // disturbance inside the running frame (R8)
      repeat (1950) @(negedge clk);
      {err, angle} = items[i];
      slow = slow_of[i];
      expq.push_back(items[i]);
    end
    wait (frames_done == NITEMS);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", frames_done, NITEMS);
    finish_run();
  end
endmodule